// File: doc/BRIEF.md
# Sun Sensor Mode Sequencer

This block is the top-level control state machine of an image-based sun sensor. It holds the sensor in a coarse acquisition mode until the profiling logic reports that the sun is present. It then switches to a fine tracking mode, in which only a small square window around the coarse sun location is read. If the sun spot fades out of that window for a whole frame, the block falls back to acquisition. Every mode change happens at a frame boundary, which the readout logic signals with `frame_end`.

Each mode has its own integration time. A telecommand can rewrite either one, or reduce the active field of view in quarter steps of the 368-pixel array. The block stages such writes and applies them only at the next frame boundary, so a frame is never exposed or windowed with mixed settings. While tracking with a valid centroid, the block sends the latest centroid to the downstream serializer as a one-cycle report pulse. Strap inputs select the report rate.

Top module: `sun_mode_seq`

## Requirements
- R1: After reset, `trk_mode` is 0 (acquisition), the window is the full array (origin 0,0, size 368) and `int_time` equals the acquisition reset value.
- R2: In acquisition, a `frame_end` with `sun_found` high switches to tracking at that boundary. The window becomes 25×25 with origin `coarse - 12` on each axis, clamped so the window stays inside the active field-of-view region.
- R3: In tracking, a frame that ends with no `peak_hit` pulse during it (the cycle of `frame_end` included) returns the block to acquisition at that boundary. A frame that has at least one `peak_hit` keeps tracking.
- R4: `int_time` shows the applied integration time of the current mode. Telecommand address 0 sets the acquisition value and address 1 sets the tracking value, independently of each other.
- R5: Telecommand writes change nothing until the next `frame_end`. A write made in the same cycle as `frame_end` is applied at that boundary.
- R6: Telecommand address 2, bits [1:0] = k, selects the field of view. The active square has side 368 − 92·k and origin 46·k on both axes.
- R7: `rate_strap` selects the report period: 2'b00 gives CLK_HZ/10 cycles (10 Hz), 2'b01 gives CLK_HZ/2 (2 Hz), 2'b10 gives CLK_HZ (1 Hz) and 2'b11 gives 2·CLK_HZ (0.5 Hz, the default of an unconnected strap).
- R8: `report_valid` pulses only in tracking, and only after a centroid has been accepted since tracking was entered. `report_x`/`report_y` carry the most recent centroid.
- R9: In acquisition, the window equals the applied active field-of-view region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end | input | 1 | One-cycle pulse marking the end of a frame |
| sun_found | input | 1 | Profiling result: sun present, valid with frame_end |
| coarse_col | input | 9 | Coarse sun column from profiling |
| coarse_row | input | 9 | Coarse sun row from profiling |
| peak_hit | input | 1 | Pulse: a window pixel exceeded the presence threshold |
| cent_valid | input | 1 | Centroid result valid pulse |
| cent_x | input | 15 | Centroid X, 9 integer + 6 fraction bits |
| cent_y | input | 15 | Centroid Y, 9 integer + 6 fraction bits |
| rate_strap | input | 2 | Report rate strap |
| tc_we | input | 1 | Telecommand write strobe |
| tc_addr | input | 2 | Telecommand register select |
| tc_data | input | 16 | Telecommand write data |
| trk_mode | output | 1 | 1 = tracking, 0 = acquisition |
| int_time | output | 16 | Integration time applied for the current mode |
| win_x0 | output | 9 | Readout window origin column |
| win_y0 | output | 9 | Readout window origin row |
| win_size | output | 9 | Readout window side length |
| report_valid | output | 1 | One-cycle position report strobe |
| report_x | output | 15 | Reported X position |
| report_y | output | 15 | Reported Y position |

## Verification
The collision that matters is a telecommand write that lands in the same cycle as `frame_end`. It must count for the boundary it coincides with, not the following one. The bench drives `tc_we` and `frame_end` together on one edge, for both an integration-time write and a field-of-view write, and checks `int_time` and the window right after that edge. A second overlap, sun loss decided at a boundary while a report period expires, is held in check by the rule that reports appear only while tracking, and the checker watches that rule every cycle.

// File: rtl/sms_pkg.sv
package sms_pkg;
    localparam int ARRAY_PIX_DEF = 368;
    localparam int WIN_PIX_DEF   = 25;

    typedef enum logic [1:0] {
        RATE_10HZ = 2'b00,
        RATE_2HZ  = 2'b01,
        RATE_1HZ  = 2'b10,
        RATE_HALF = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        TC_IT_ACQ = 2'd0,
        TC_IT_TRK = 2'd1,
        TC_FOV    = 2'd2
    } tc_reg_e;
endpackage

// File: rtl/sms_rate_timer.sv
module sms_rate_timer #(
    parameter int CLK_HZ = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    output logic       tick
);
    import sms_pkg::*;

    localparam int CNT_W = $clog2(2 * CLK_HZ + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        case (rate_e'(rate_sel))
            RATE_10HZ: limit = CNT_W'(CLK_HZ / 10);
            RATE_2HZ:  limit = CNT_W'(CLK_HZ / 2);
            RATE_1HZ:  limit = CNT_W'(CLK_HZ);
            default:   limit = CNT_W'(2 * CLK_HZ);
        endcase
        tick  = (cnt_q >= limit - CNT_W'(1));
        cnt_d = tick ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sms_axis_window.sv
module sms_axis_window #(
    parameter int ARRAY_PIX = 368,
    parameter int WIN_PIX   = 25,
    parameter int CW        = 9
) (
    input  logic          trk,
    input  logic [1:0]    fov,
    input  logic [CW-1:0] coarse,
    output logic [CW-1:0] origin,
    output logic [CW-1:0] size
);
    localparam int STEP = ARRAY_PIX / 4;
    localparam int HALF = STEP / 2;

    int lo, span, hi, want;

    always_comb begin
        span = ARRAY_PIX - int'(fov) * STEP;
        lo   = int'(fov) * HALF;
        hi   = lo + span - WIN_PIX;
        want = int'(coarse) - WIN_PIX / 2;
        if (want < lo) want = lo;
        if (want > hi) want = hi;
        if (trk) begin
            origin = CW'(want);
            size   = CW'(WIN_PIX);
        end else begin
            origin = CW'(lo);
            size   = CW'(span);
        end
    end
endmodule

// File: rtl/sun_mode_seq.sv
module sun_mode_seq #(
    parameter int CLK_HZ     = 1000000,
    parameter int ARRAY_PIX  = sms_pkg::ARRAY_PIX_DEF,
    parameter int WIN_PIX    = sms_pkg::WIN_PIX_DEF,
    parameter int IT_W       = 16,
    parameter int POS_W      = 15,
    parameter int IT_ACQ_RST = 100,
    parameter int IT_TRK_RST = 40,
    parameter int CW         = $clog2(ARRAY_PIX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  logic             sun_found,
    input  logic [CW-1:0]    coarse_col,
    input  logic [CW-1:0]    coarse_row,
    input  logic             peak_hit,
    input  logic             cent_valid,
    input  logic [POS_W-1:0] cent_x,
    input  logic [POS_W-1:0] cent_y,
    input  logic [1:0]       rate_strap,
    input  logic             tc_we,
    input  logic [1:0]       tc_addr,
    input  logic [IT_W-1:0]  tc_data,
    output logic             trk_mode,
    output logic [IT_W-1:0]  int_time,
    output logic [CW-1:0]    win_x0,
    output logic [CW-1:0]    win_y0,
    output logic [CW-1:0]    win_size,
    output logic             report_valid,
    output logic [POS_W-1:0] report_x,
    output logic [POS_W-1:0] report_y
);
    import sms_pkg::*;

    typedef struct packed {
        logic             trk;
        logic             hit;
        logic             have;
        logic [CW-1:0]    cx;
        logic [CW-1:0]    cy;
        logic [IT_W-1:0]  stg_acq;
        logic [IT_W-1:0]  stg_trk;
        logic [1:0]       stg_fov;
        logic [IT_W-1:0]  app_acq;
        logic [IT_W-1:0]  app_trk;
        logic [1:0]       app_fov;
        logic [POS_W-1:0] rx;
        logic [POS_W-1:0] ry;
        logic             rv;
    } seq_t;

    seq_t st_d, st_q;
    logic tick;
    logic [CW-1:0] size_x, size_y;
    logic [CW-1:0] coarse_ax [2];
    logic [CW-1:0] origin_ax [2];
    logic [CW-1:0] size_ax   [2];

    sms_rate_timer #(.CLK_HZ(CLK_HZ)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_strap),
        .tick     (tick)
    );

    assign coarse_ax[0] = st_q.cx;
    assign coarse_ax[1] = st_q.cy;

    for (genvar a = 0; a < 2; a++) begin : g_axis
        sms_axis_window #(
            .ARRAY_PIX (ARRAY_PIX),
            .WIN_PIX   (WIN_PIX),
            .CW        (CW)
        ) u_axis (
            .trk    (st_q.trk),
            .fov    (st_q.app_fov),
            .coarse (coarse_ax[a]),
            .origin (origin_ax[a]),
            .size   (size_ax[a])
        );
    end

    assign size_x = size_ax[0];
    assign size_y = size_ax[1];

    always_comb begin
        st_d = st_q;

        if (tc_we) begin
            case (tc_reg_e'(tc_addr))
                TC_IT_ACQ: st_d.stg_acq = tc_data;
                TC_IT_TRK: st_d.stg_trk = tc_data;
                TC_FOV:    st_d.stg_fov = tc_data[1:0];
                default:   ;
            endcase
        end

        if (frame_end) st_d.hit = 1'b0;
        else if (peak_hit) st_d.hit = 1'b1;

        if (frame_end) begin
            st_d.app_acq = st_d.stg_acq;
            st_d.app_trk = st_d.stg_trk;
            st_d.app_fov = st_d.stg_fov;
            if (!st_q.trk && sun_found) begin
                st_d.trk  = 1'b1;
                st_d.have = 1'b0;
                st_d.cx   = coarse_col;
                st_d.cy   = coarse_row;
            end else if (st_q.trk && !(st_q.hit || peak_hit)) begin
                st_d.trk  = 1'b0;
                st_d.have = 1'b0;
            end
        end

        if (cent_valid && st_q.trk && st_d.trk) begin
            st_d.rx   = cent_x;
            st_d.ry   = cent_y;
            st_d.have = 1'b1;
        end

        st_d.rv = tick && st_d.trk && st_d.have;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.stg_acq <= IT_W'(IT_ACQ_RST);
            st_q.stg_trk <= IT_W'(IT_TRK_RST);
            st_q.app_acq <= IT_W'(IT_ACQ_RST);
            st_q.app_trk <= IT_W'(IT_TRK_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign trk_mode     = st_q.trk;
    assign int_time     = st_q.trk ? st_q.app_trk : st_q.app_acq;
    assign win_x0       = origin_ax[0];
    assign win_y0       = origin_ax[1];
    assign win_size     = (size_x > size_y) ? size_x : size_y;
    assign report_valid = st_q.rv;
    assign report_x     = st_q.rx;
    assign report_y     = st_q.ry;
endmodule

// File: rtl/sms_checks.sv
module sms_checks #(
    parameter int ARRAY_PIX = 368,
    parameter int WIN_PIX   = 25,
    parameter int IT_W      = 16,
    parameter int CW        = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_end,
    input logic            trk_mode,
    input logic [IT_W-1:0] int_time,
    input logic [CW-1:0]   win_x0,
    input logic [CW-1:0]   win_y0,
    input logic [CW-1:0]   win_size,
    input logic            report_valid
);
    // R1: leaving reset always lands in acquisition
    assert_reset_acq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !trk_mode);

    // R3: mode only changes right after a frame boundary
    assert_mode_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_end) |-> $stable(trk_mode));

    // R5: applied integration time never moves mid-frame
    assert_it_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_end) |-> $stable(int_time));

    // R2: tracking always reads the small window
    assert_trk_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trk_mode |-> (int'(win_size) == WIN_PIX));

    // R6: window stays inside the array
    assert_window_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(win_x0) + int'(win_size) <= ARRAY_PIX) &&
        (int'(win_y0) + int'(win_size) <= ARRAY_PIX));

    // R8: reports only while tracking
    assert_report_in_trk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        report_valid |-> trk_mode);

    // R7: a report is a single-cycle pulse
    assert_report_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        report_valid |=> !report_valid);
endmodule

bind sun_mode_seq sms_checks #(
    .ARRAY_PIX (ARRAY_PIX),
    .WIN_PIX   (WIN_PIX),
    .IT_W      (IT_W),
    .CW        (CW)
) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_end    (frame_end),
    .trk_mode     (trk_mode),
    .int_time     (int_time),
    .win_x0       (win_x0),
    .win_y0       (win_y0),
    .win_size     (win_size),
    .report_valid (report_valid)
);

// File: tb/sun_mode_seq_test.sv
`timescale 1ns/1ps
module sun_mode_seq_test;
    localparam int CLK_HZ = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_end = 1'b0, sun_found = 1'b0, peak_hit = 1'b0, cent_valid = 1'b0;
    logic [8:0]  coarse_col = '0, coarse_row = '0;
    logic [14:0] cent_x = '0, cent_y = '0;
    logic [1:0]  rate_strap = 2'b11;
    logic        tc_we = 1'b0;
    logic [1:0]  tc_addr = '0;
    logic [15:0] tc_data = '0;
    logic        trk_mode, report_valid;
    logic [15:0] int_time;
    logic [8:0]  win_x0, win_y0, win_size;
    logic [14:0] report_x, report_y;

    int n_run = 0, n_fail = 0, cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sun_mode_seq #(.CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .sun_found(sun_found),
        .coarse_col(coarse_col), .coarse_row(coarse_row), .peak_hit(peak_hit),
        .cent_valid(cent_valid), .cent_x(cent_x), .cent_y(cent_y),
        .rate_strap(rate_strap), .tc_we(tc_we), .tc_addr(tc_addr), .tc_data(tc_data),
        .trk_mode(trk_mode), .int_time(int_time), .win_x0(win_x0), .win_y0(win_y0),
        .win_size(win_size), .report_valid(report_valid),
        .report_x(report_x), .report_y(report_y)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int fov_lo(input int k);   return 46 * k;       endfunction
    function automatic int fov_span(input int k); return 368 - 92 * k; endfunction
    function automatic int exp_org(input int c, input int k);
        int v = c - 12;
        if (v < fov_lo(k)) v = fov_lo(k);
        if (v > fov_lo(k) + fov_span(k) - 25) v = fov_lo(k) + fov_span(k) - 25;
        return v;
    endfunction
    function automatic int exp_period(input logic [1:0] s);
        case (s)
            2'b00: return CLK_HZ / 10;
            2'b01: return CLK_HZ / 2;
            2'b10: return CLK_HZ;
            default: return 2 * CLK_HZ;
        endcase
    endfunction

    task automatic frame(input logic sun, input logic hit, input int col, input int row);
        @(negedge clk);
        frame_end = 1'b1; sun_found = sun; peak_hit = hit;
        coarse_col = 9'(col); coarse_row = 9'(row);
        @(negedge clk);
        frame_end = 1'b0; sun_found = 1'b0; peak_hit = 1'b0;
    endtask

    task automatic tc_write(input int addr, input int data);
        @(negedge clk);
        tc_we = 1'b1; tc_addr = 2'(addr); tc_data = 16'(data);
        @(negedge clk);
        tc_we = 1'b0;
    endtask

    task automatic gap(output int g);
        g = 0;
        while (!report_valid && !done) @(negedge clk);
        @(negedge clk); g = 1;
        while (!report_valid && !done) begin @(negedge clk); g++; end
    endtask

    task automatic check_acq_window(input string req, input int k);
        check({req, " x0"}, int'(win_x0), fov_lo(k));
        check({req, " y0"}, int'(win_y0), fov_lo(k));
        check({req, " size"}, int'(win_size), fov_span(k));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_fail++; n_run++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int g;
        int k;
        int c, r;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R9: reset state
        check("R1 mode", int'(trk_mode), 0);
        check("R1 int_time", int'(int_time), 100);
        check_acq_window("R1 R9", 0);

        // R5: staged write has no effect until boundary
        tc_write(0, 555);
        repeat (3) @(negedge clk);
        check("R5 before boundary", int'(int_time), 100);
        frame(0, 0, 0, 0);
        check("R4 R5 acq it applied", int'(int_time), 555);

        // R4: tracking value independent
        tc_write(1, 77);
        frame(0, 0, 0, 0);
        check("R4 acq unchanged", int'(int_time), 555);

        // R5: same-cycle write and boundary
        @(negedge clk);
        tc_we = 1'b1; tc_addr = 2'd2; tc_data = 16'd1; frame_end = 1'b1;
        @(negedge clk);
        tc_we = 1'b0; frame_end = 1'b0;
        check_acq_window("R5 R6 fov same cycle", 1);
        @(negedge clk);
        tc_we = 1'b1; tc_addr = 2'd0; tc_data = 16'd321; frame_end = 1'b1;
        @(negedge clk);
        tc_we = 1'b0; frame_end = 1'b0;
        check("R5 it same cycle", int'(int_time), 321);

        // R6: every field of view
        for (int f = 0; f < 4; f++) begin
            tc_write(2, f);
            frame(0, 0, 0, 0);
            check_acq_window("R6 R9 fov", f);
        end
        tc_write(2, 0);
        frame(0, 0, 0, 0);

        // R2: enter tracking with a centre near the top-left edge
        frame(1, 0, 5, 200);
        check("R2 to trk", int'(trk_mode), 1);
        check("R2 x0 clamp", int'(win_x0), exp_org(5, 0));
        check("R2 y0", int'(win_y0), exp_org(200, 0));
        check("R2 size", int'(win_size), 25);
        check("R4 trk it", int'(int_time), 77);

        // R3: frame with a hit keeps tracking
        frame(0, 1, 0, 0);
        check("R3 stay", int'(trk_mode), 1);

        // R8: no report without a centroid
        rate_strap = 2'b00;
        g = 0;
        repeat (450) begin @(negedge clk); if (report_valid) g++; end
        check("R8 no centroid no report", g, 0);

        @(negedge clk);
        cent_valid = 1'b1; cent_x = 15'h1234; cent_y = 15'h0abc;
        @(negedge clk);
        cent_valid = 1'b0;
        gap(g);
        check("R8 report x", int'(report_x), 'h1234);
        check("R8 report y", int'(report_y), 'h0abc);

        // R7: report period for each strap code
        for (int s = 0; s < 4; s++) begin
            rate_strap = 2'(s);
            gap(g);
            gap(g);
            check($sformatf("R7 period strap %0d", s), g, exp_period(2'(s)));
        end
        rate_strap = 2'b00;

        // R3: empty frame drops back to acquisition, R8 reports stop
        frame(0, 0, 0, 0);
        check("R3 lost", int'(trk_mode), 0);
        check_acq_window("R3 R9 acq window", 0);
        g = 0;
        repeat (450) begin @(negedge clk); if (report_valid) g++; end
        check("R8 no report in acq", g, 0);

        // random field of view and coarse positions
        for (int i = 0; i < 12; i++) begin
            k = int'($urandom_range(3, 0));
            c = int'($urandom_range(367, 0));
            r = (i == 0) ? 367 : int'($urandom_range(367, 0));
            tc_write(2, k);
            frame(0, 0, 0, 0);
            check_acq_window("R6 R9 rand", k);
            frame(1, 0, c, r);
            check("R2 rand trk", int'(trk_mode), 1);
            check("R2 rand x0", int'(win_x0), exp_org(c, k));
            check("R2 rand y0", int'(win_y0), exp_org(r, k));
            frame(0, 0, 0, 0);
            check("R3 rand lost", int'(trk_mode), 0);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule